// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block is a hardware sequencer. It reads and writes 16-bit registers inside a PHY through a narrow control-register port. The port has two words. The sequencer drives a control word that holds a data field and four one-bit strobes. The PHY answers with a status word that holds a data field and one acknowledge bit. Every strobe completes a full four-phase handshake: the strobe goes high, the PHY raises the acknowledge, the strobe goes low, and the PHY drops the acknowledge.

A host gives the block one command at a time: an address, write data and a write/read select. A write runs three handshakes in turn: latch address, latch data, then commit write. A read runs two: latch address, then fetch read data. The block reports the result with a one-cycle done pulse, or with a one-cycle timeout pulse when an acknowledge does not arrive within the poll budget. Read data stays on `rd_data` until the next read overwrites it.

Top module: `phy_cr_master`

## Requirements
- R1: While reset is held and after it is released, `phy_ctl` is zero and `busy`, `done` and `timeout_err` are low.
- R2: A command is taken only on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is high from the edge after that until the edge that raises `done` or `timeout_err`. A command offered while `busy` is high has no effect on the port.
- R3: The control word places the data field in bits [15:0], latch-address in bit 16, latch-data in bit 17, commit-write in bit 18 and fetch-read in bit 19. At most one of bits [19:16] is high at any time, and the whole word is zero when the block is idle.
- R4: Address phase: the address is driven on bits [15:0] with bit 16 high. Once the acknowledge (status bit 16) is seen high, bit 16 drops while the address stays on the data field. The block then waits for the acknowledge to be low.
- R5: A write performs, in order: the address phase, a latch-data handshake with the write data held on bits [15:0], and a commit-write handshake with the data field zero. The control word is zero when the write finishes.
- R6: A read performs the address phase, then raises bit 19 with the data field zero. In the cycle the acknowledge is seen high, it samples status bits [15:0] into `rd_data`. It then clears the control word and waits for the acknowledge to be low.
- R7: Each acknowledge wait polls once per clock, for at most MAX_POLLS (default 100) polls. A match on the last allowed poll still succeeds. If there is no match by then, `timeout_err` pulses, all strobes clear in the same edge, and the block returns to idle.
- R8: The poll budget starts again at every acknowledge wait. A transaction whose waits each use nearly the full budget still completes, however long it takes in total.
- R9: `done` is a single-cycle pulse, raised by the edge at which the last acknowledge-low is seen. Each handshake phase ends on the edge at which its acknowledge level is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | One-cycle abort pulse on an expired acknowledge wait |
| rd_data | output | 16 | Data of the most recent read |
| phy_ctl | output | 20 | Control word to the PHY port |
| phy_sts | input | 17 | Status word from the PHY port (bit 16 = acknowledge) |

## Verification
The bench uses a PHY responder whose acknowledge delay can be set. It checks the boundary of the poll budget on both sides: a delay that lands on the last allowed poll must succeed, and one cycle more must abort. A counter that is off by one would fail one of these two. A responder that holds its acknowledge high checks that a falling-edge wait also times out and leaves every strobe clear. A long transaction with near-limit delays in every phase catches a counter that is not restarted, because such a counter would abort partway through. The bench also offers a spurious command while busy, then reads back the register that command named. It checks the strobe order and the data field at each strobe rise, which exposes a swapped phase, an address not held, or a dropped commit.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_HI,
        ST_RD_LO
    } cr_state_e;

    localparam int NUM_STROBES = 4;
    localparam int STB_ADR = 0;
    localparam int STB_DAT = 1;
    localparam int STB_WR  = 2;
    localparam int STB_RD  = 3;

    function automatic logic waits_for_high(cr_state_e s);
        return (s == ST_ADR_HI) || (s == ST_DAT_HI) ||
               (s == ST_WR_HI)  || (s == ST_RD_HI);
    endfunction

endpackage

// File: rtl/cr_ack_waiter.sv
module cr_ack_waiter #(
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic expect_hi,
    input  logic ack,
    output logic hit,
    output logic expired
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit     = active && (ack == expect_hi);
        expired = active && !hit && (cnt_q == LAST);
        if (!active || hit || expired) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/cr_ctl_pack.sv
module cr_ctl_pack
    import cr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  cr_state_e               state,
    input  logic [DATA_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W+NUM_STROBES-1:0] word
);
    logic [NUM_STROBES-1:0] stb;
    logic [DATA_W-1:0]      field;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        localparam cr_state_e HI_ST = (g == STB_ADR) ? ST_ADR_HI :
                                      (g == STB_DAT) ? ST_DAT_HI :
                                      (g == STB_WR)  ? ST_WR_HI  : ST_RD_HI;
        assign stb[g] = (state == HI_ST);
    end

    always_comb begin
        case (state)
            ST_ADR_HI, ST_ADR_LO: field = addr;
            ST_DAT_HI, ST_DAT_LO: field = wdata;
            default:              field = '0;
        endcase
        word = {stb, field};
    end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
    import cr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_POLLS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W+3:0] phy_ctl,
    input  logic [DATA_W:0]   phy_sts
);
    localparam int ACK_BIT = DATA_W;

    typedef struct packed {
        cr_state_e         st;
        logic              wr;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic hit, expired, active;

    assign active = (seq_q.st != ST_IDLE);

    cr_ack_waiter #(.MAX_POLLS(MAX_POLLS)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .expect_hi (waits_for_high(seq_q.st)),
        .ack       (phy_sts[ACK_BIT]),
        .hit       (hit),
        .expired   (expired)
    );

    cr_ctl_pack #(.DATA_W(DATA_W)) u_pack (
        .state (seq_q.st),
        .addr  (seq_q.addr),
        .wdata (seq_q.wdata),
        .word  (phy_ctl)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        if (seq_q.st == ST_IDLE) begin
            if (cmd_valid) begin
                seq_d.st    = ST_ADR_HI;
                seq_d.wr    = cmd_write;
                seq_d.addr  = cmd_addr;
                seq_d.wdata = cmd_wdata;
            end
        end else if (expired) begin
            seq_d.st  = ST_IDLE;
            seq_d.err = 1'b1;
        end else if (hit) begin
            case (seq_q.st)
                ST_ADR_HI: seq_d.st = ST_ADR_LO;
                ST_ADR_LO: seq_d.st = seq_q.wr ? ST_DAT_HI : ST_RD_HI;
                ST_DAT_HI: seq_d.st = ST_DAT_LO;
                ST_DAT_LO: seq_d.st = ST_WR_HI;
                ST_WR_HI:  seq_d.st = ST_WR_LO;
                ST_RD_HI: begin
                    seq_d.st    = ST_RD_LO;
                    seq_d.rdata = phy_sts[DATA_W-1:0];
                end
                ST_WR_LO, ST_RD_LO: begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, wr: 1'b0, addr: '0, wdata: '0,
                       rdata: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy        = active;
    assign done        = seq_q.done;
    assign timeout_err = seq_q.err;
    assign rd_data     = seq_q.rdata;
endmodule

// File: rtl/phy_cr_master_sva.sv
module phy_cr_master_sva #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout_err,
    input logic [DATA_W+3:0] phy_ctl,
    input logic [DATA_W:0]   phy_sts
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> phy_ctl == '0); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctl[DATA_W+3:DATA_W])); // R3
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err)); // R7
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !busy && phy_ctl == '0); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $fell(phy_ctl[DATA_W]) |->
            phy_ctl[DATA_W-1:0] == $past(phy_ctl[DATA_W-1:0])); // R4
    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ($past(phy_ctl[DATA_W+3:DATA_W]) != 4'b0) &&
            (phy_ctl[DATA_W+3:DATA_W] == 4'b0) |-> $past(phy_sts[DATA_W])); // R4
endmodule

bind phy_cr_master phy_cr_master_sva #(.DATA_W(DATA_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .phy_ctl     (phy_ctl),
    .phy_sts     (phy_sts)
);

// File: tb/phy_cr_master_test.sv
module phy_cr_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, timeout_err;
    logic [15:0] rd_data;
    logic [19:0] phy_ctl;
    logic [16:0] phy_sts;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    phy_cr_master uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .timeout_err(timeout_err), .rd_data(rd_data), .phy_ctl(phy_ctl),
        .phy_sts(phy_sts)
    );

    // PHY responder model
    logic        ack_q;
    int          lat = 0;
    bit          hold = 1'b0;
    int          dly;
    logic [15:0] mem [16];
    logic [15:0] cap_a, cap_d;
    logic [3:0]  stb_prev;
    int          log_n;
    int          log_code [64];
    logic [15:0] log_dat [64];
    wire  [3:0]  stb = phy_ctl[19:16];
    wire         any_stb = |stb;

    assign phy_sts = {ack_q, mem[cap_a[3:0]]};

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0; dly <= 0; stb_prev <= '0; log_n <= 0;
            cap_a <= '0; cap_d <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i);
        end else begin
            stb_prev <= stb;
            if (any_stb != ack_q && !(hold && ack_q)) begin
                if (dly >= lat) begin ack_q <= any_stb; dly <= 0; end
                else dly <= dly + 1;
            end else dly <= 0;
            for (int b = 0; b < 4; b++) begin
                if (stb[b] && !stb_prev[b]) begin
                    log_code[log_n % 64] <= b + 1;
                    log_dat[log_n % 64]  <= phy_ctl[15:0];
                    log_n <= log_n + 1;
                    if (b == 0) cap_a <= phy_ctl[15:0];
                    if (b == 1) cap_d <= phy_ctl[15:0];
                    if (b == 2) mem[cap_a[3:0]] <= cap_d;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        while (ack_q || busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input int inject, output int n, output bit gd, output bit ge);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        n = 0;
        check(busy == 1'b1, "R2", "busy after accept", busy, 1);
        if (inject > 0) begin
            cmd_write = 1'b1; cmd_addr = 16'h0006; cmd_wdata = 16'h2222;
        end else cmd_valid = 1'b0;
        while (!(done || timeout_err) && n < 5000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n >= inject) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        gd = done; ge = timeout_err;
    endtask

    task automatic t_reset();
        check(phy_ctl == '0 && !busy && !done && !timeout_err, "R1", "reset state",
              {busy, done, timeout_err}, 0);
    endtask

    task automatic t_write_basic();
        int n; bit gd, ge; int base;
        lat = 0; base = log_n;
        run_cmd(1'b1, 16'h0003, 16'hA5C3, 0, n, gd, ge);
        check(gd && !ge, "R5", "write done", {gd, ge}, 2);
        check(n == 12, "R9", "write edges", n, 12);
        check(log_n - base == 3 && log_code[base % 64] == 1 &&
              log_code[(base + 1) % 64] == 2 && log_code[(base + 2) % 64] == 3,
              "R5", "strobe order", log_n - base, 3);
        check(log_dat[base % 64] == 16'h0003, "R4", "address field",
              log_dat[base % 64], 16'h0003);
        check(log_dat[(base + 1) % 64] == 16'hA5C3 && log_dat[(base + 2) % 64] == 16'h0,
              "R3", "data fields", log_dat[(base + 1) % 64], 16'hA5C3);
        @(negedge clk);
        check(!done && phy_ctl == '0 && !busy, "R9", "done one pulse, word zero",
              {done, busy}, 0);
        settle();
    endtask

    task automatic t_read_basic();
        int n; bit gd, ge; int base;
        lat = 0; base = log_n;
        run_cmd(1'b0, 16'h0003, 16'hFFFF, 0, n, gd, ge);
        check(gd && n == 8, "R6", "read edges", n, 8);
        check(rd_data == 16'hA5C3, "R6", "read data", rd_data, 16'hA5C3);
        check(log_n - base == 2 && log_code[(base + 1) % 64] == 4 &&
              log_dat[(base + 1) % 64] == 16'h0, "R6", "read strobe", log_n - base, 2);
        settle();
        lat = 3;
        run_cmd(1'b0, 16'h0007, 16'h0, 0, n, gd, ge);
        check(gd && n == 20, "R9", "read edges lat3", n, 20);
        check(rd_data == 16'h1007, "R6", "read reset value", rd_data, 16'h1007);
        settle();
    endtask

    task automatic t_busy_ignore();
        int n; bit gd, ge; int base;
        lat = 2; base = log_n;
        run_cmd(1'b1, 16'h0005, 16'h1111, 3, n, gd, ge);
        check(gd && n == 24, "R2", "write edges with spurious cmd", n, 24);
        settle();
        check(log_n - base == 3, "R2", "no extra transaction", log_n - base, 3);
        lat = 0;
        run_cmd(1'b0, 16'h0006, 16'h0, 0, n, gd, ge);
        check(rd_data == 16'h1006, "R2", "spurious write not made", rd_data, 16'h1006);
        settle();
    endtask

    task automatic t_budget_edge();
        int n; bit gd, ge;
        lat = 98;
        run_cmd(1'b1, 16'h0009, 16'h0F0F, 0, n, gd, ge);
        check(gd && !ge && n == 600, "R8", "near-limit write", n, 600);
        settle();
        lat = 0;
        run_cmd(1'b0, 16'h0009, 16'h0, 0, n, gd, ge);
        check(rd_data == 16'h0F0F, "R7", "last-poll ack accepted", rd_data, 16'h0F0F);
        settle();
    endtask

    task automatic t_timeout_rise();
        int n; bit gd, ge;
        lat = 99;
        run_cmd(1'b1, 16'h000A, 16'h7777, 0, n, gd, ge);
        check(ge && !gd && n == 100, "R7", "rise timeout edges", n, 100);
        check(phy_ctl == '0 && !busy, "R7", "strobes cleared", phy_ctl, 0);
        settle();
    endtask

    task automatic t_timeout_fall();
        int n; bit gd, ge;
        lat = 0; hold = 1'b1;
        run_cmd(1'b0, 16'h0002, 16'h0, 0, n, gd, ge);
        check(ge && !gd && n == 102, "R7", "fall timeout edges", n, 102);
        check(phy_ctl == '0 && !busy, "R7", "idle after fall timeout", phy_ctl, 0);
        hold = 1'b0;
        settle();
        run_cmd(1'b0, 16'h0002, 16'h0, 0, n, gd, ge);
        check(gd && rd_data == 16'h1002, "R7", "recovers after abort", rd_data, 16'h1002);
        settle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_busy_ignore();
        t_budget_edge();
        t_timeout_rise();
        t_timeout_fall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule